// File: doc/BRIEF.md
# Bit-Serial Add-Compare-Select Butterfly

This block is one add-compare-select butterfly for a Viterbi decoder. All arithmetic runs one bit per clock. Two predecessor path metrics and two branch metrics arrive as serial streams, least significant bit first, in words of `PM_W` bits (8 by default). The block forms the four candidate sums of the butterfly and picks the smaller candidate for each of the two successor states. It produces one decision bit per successor and holds each surviving metric in an internal `PM_W`-deep shift register. That register shifts a new bit in and the oldest bit out on every enabled clock.

In a full decoder the block is replicated once per pair of states: 128 copies serve a 256-state code. The serial metric outputs of one copy are routed to the predecessor inputs of other copies. Branch metric generation, normalisation across the array and survivor storage are outside this block. A word boundary is counted internally on enabled clocks only. Holding `en` low freezes every register.

Top module: `acs_bitserial_butterfly`

## Requirements
- R1: After reset, and while `en` stays low, `pm_out0`, `pm_out1`, `dec0`, `dec1` and `word_done` are all 0.
- R2: A word is `PM_W` consecutive clocks with `en` high, bit 0 (LSB) first. A clock with `en` low changes no state: the serial outputs hold their value, `word_done` stays 0 and the decisions hold.
- R3: Successor 0 selects the smaller of `pm0 + bm_a` (first predecessor) and `pm1 + bm_b` (second predecessor). Successor 1 selects the smaller of `pm0 + bm_b` and `pm1 + bm_a`.
- R4: `decN` is 1 when the candidate from the second predecessor is strictly smaller than the one from the first, compared at full precision including the carry. On a tie it is 0. It changes only together with a `word_done` pulse and holds otherwise.
- R5: A selected sum above 2^PM_W - 1 is stored as 2^PM_W - 1 (all ones) instead of wrapping.
- R6: `word_done` is high for exactly one clock, right after the edge that takes in bit `PM_W-1` of a word. `dec0` and `dec1` carry that word's decisions from the same clock on.
- R7: The new metric of word k leaves on `pm_out0`/`pm_out1`, LSB first, during the enabled clocks of word k+2, in step with the bit index. During words 0 and 1 both outputs are 0.
- R8: Adder carries and comparison state begin afresh with each word. A carry out of one word never affects the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable; one serial bit per high clock |
| pm_in0 | input | 1 | Serial metric of the first predecessor state |
| pm_in1 | input | 1 | Serial metric of the second predecessor state |
| bm_a | input | 1 | Serial branch metric on the straight transitions |
| bm_b | input | 1 | Serial branch metric on the crossed transitions |
| pm_out0 | output | 1 | Serial stored metric of successor 0 |
| pm_out1 | output | 1 | Serial stored metric of successor 1 |
| dec0 | output | 1 | Decision of successor 0 (1 = second predecessor) |
| dec1 | output | 1 | Decision of successor 1 (1 = second predecessor) |
| word_done | output | 1 | One-clock pulse at the end of each word |

## Verification
The bench builds the block with the default `PM_W` of 8. With that width, random 8-bit metrics and branch metrics make carry-out sums common, so saturation, one-sided overflow and equal overflowed sums all occur next to ordinary sums. Directed words add exact ties, differences only in the LSB or only in the MSB, and a large-sum word followed by an all-zero word to expose a leaked carry. Idle gaps of varying length between words exercise the freeze behaviour.

// File: rtl/acs_bs_pkg.sv
package acs_bs_pkg;

  localparam int unsigned ACS_PM_W_DEFAULT = 8;

  // serial candidate: current sum bit and its carry out
  typedef struct packed {
    logic sum_bit;
    logic carry;
  } acs_cand_t;

  function automatic logic acs_maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/acs_bs_rst_sync.sv
module acs_bs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/acs_bs_adder.sv
module acs_bs_adder
  import acs_bs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      first,
  input  logic      a_bit,
  input  logic      b_bit,
  output acs_cand_t cand
);

  logic carry_q;
  logic carry_d;
  logic cin;

  always_comb begin
    cin          = first ? 1'b0 : carry_q;
    cand.sum_bit = a_bit ^ b_bit ^ cin;
    cand.carry   = acs_maj3(a_bit, b_bit, cin);
    carry_d      = en ? cand.carry : carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

endmodule

// File: rtl/acs_bs_cmp.sv
module acs_bs_cmp
  import acs_bs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      first,
  input  acs_cand_t cand_a,
  input  acs_cand_t cand_b,
  output logic      b_less
);

  logic lt_q;
  logic lt_d;
  logic lt_prev;
  logic lt_now;

  always_comb begin
    lt_prev = first ? 1'b0 : lt_q;
    // a later (more significant) differing bit overrides earlier ones
    lt_now  = (cand_a.sum_bit ^ cand_b.sum_bit) ? cand_a.sum_bit : lt_prev;
    // carry is the top bit of the full-precision sum; valid on the last bit
    b_less  = (cand_a.carry ^ cand_b.carry) ? cand_a.carry : lt_now;
    lt_d    = en ? lt_now : lt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lt_q <= 1'b0;
    else        lt_q <= lt_d;
  end

endmodule

// File: rtl/acs_bs_shift.sv
module acs_bs_shift #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_d;

  always_comb begin
    line_d = en ? {din, line_q[DEPTH-1:1]} : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[0];

endmodule

// File: rtl/acs_bitserial_butterfly.sv
module acs_bitserial_butterfly
  import acs_bs_pkg::*;
#(
  parameter int unsigned PM_W = ACS_PM_W_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pm_in0,
  input  logic pm_in1,
  input  logic bm_a,
  input  logic bm_b,
  output logic pm_out0,
  output logic pm_out1,
  output logic dec0,
  output logic dec1,
  output logic word_done
);

  localparam int unsigned CNT_W   = (PM_W > 2) ? $clog2(PM_W) : 1;
  localparam int unsigned N_SUCC  = 2;
  localparam int unsigned N_PRED  = 2;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PM_W - 1);

  logic rst_sync_n;

  acs_bs_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // bit position within the word
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] bit_cnt_d;
  logic             first_bit;
  logic             last_bit;
  logic             done_q;
  logic             done_d;

  always_comb begin
    first_bit = (bit_cnt == '0);
    last_bit  = (bit_cnt == LAST_IDX);
    bit_cnt_d = bit_cnt;
    if (en) bit_cnt_d = last_bit ? '0 : bit_cnt + 1'b1;
    done_d    = en & last_bit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bit_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      bit_cnt <= bit_cnt_d;
      done_q  <= done_d;
    end
  end

  assign word_done = done_q;

  logic [N_SUCC-1:0] pm_out_v;
  logic [N_SUCC-1:0] dec_v;

  for (genvar j = 0; j < N_SUCC; j++) begin : g_succ
    acs_cand_t [N_PRED-1:0] cand;
    logic      [N_PRED-1:0] buf_out;
    logic                   pick_second;
    logic                   sel_q;
    logic                   sel_d;
    logic                   sat_q;
    logic                   sat_d;
    logic                   fifo_in;

    for (genvar p = 0; p < N_PRED; p++) begin : g_pred
      logic pm_bit;
      logic bm_bit;

      assign pm_bit = (p == 0) ? pm_in0 : pm_in1;
      // straight transition uses bm_a, crossed transition uses bm_b
      assign bm_bit = (p == j) ? bm_a : bm_b;

      acs_bs_adder u_add (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (en),
        .first (first_bit),
        .a_bit (pm_bit),
        .b_bit (bm_bit),
        .cand  (cand[p])
      );

      // holds the candidate for one word until the decision is known
      acs_bs_shift #(.DEPTH(PM_W)) u_cbuf (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (en),
        .din   (cand[p].sum_bit),
        .dout  (buf_out[p])
      );
    end

    acs_bs_cmp u_cmp (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (en),
      .first  (first_bit),
      .cand_a (cand[0]),
      .cand_b (cand[1]),
      .b_less (pick_second)
    );

    always_comb begin
      sel_d = sel_q;
      sat_d = sat_q;
      if (en && last_bit) begin
        sel_d = pick_second;
        sat_d = pick_second ? cand[1].carry : cand[0].carry;
      end
      fifo_in = sat_q | (sel_q ? buf_out[1] : buf_out[0]);
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        sel_q <= 1'b0;
        sat_q <= 1'b0;
      end else begin
        sel_q <= sel_d;
        sat_q <= sat_d;
      end
    end

    // path metric store: one bit in and one bit out per enabled clock
    acs_bs_shift #(.DEPTH(PM_W)) u_pm_fifo (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (en),
      .din   (fifo_in),
      .dout  (pm_out_v[j])
    );

    assign dec_v[j] = sel_q;
  end

  assign pm_out0 = pm_out_v[0];
  assign pm_out1 = pm_out_v[1];
  assign dec0    = dec_v[0];
  assign dec1    = dec_v[1];

endmodule

// File: rtl/acs_butterfly_chk.sv
module acs_butterfly_chk #(
  parameter int unsigned PM_W  = 8,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             word_done,
  input logic             dec0,
  input logic             dec1,
  input logic             pm_out0,
  input logic             pm_out1,
  input logic [CNT_W-1:0] bit_cnt
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> ($past(en) && ($past(bit_cnt) == CNT_W'(PM_W - 1)))); // R6

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |-> ($stable(dec0) && $stable(dec1))); // R4

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pm_out0) && $stable(pm_out1) && !word_done)); // R2

endmodule

bind acs_bitserial_butterfly acs_butterfly_chk #(
  .PM_W  (PM_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (en),
  .word_done (word_done),
  .dec0      (dec0),
  .dec1      (dec1),
  .pm_out0   (pm_out0),
  .pm_out1   (pm_out1),
  .bit_cnt   (bit_cnt)
);

// File: tb/acs_bitserial_butterfly_tb.sv
module acs_bitserial_butterfly_tb;

  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk;
  logic rst_n, en, pm_in0, pm_in1, bm_a, bm_b;
  logic pm_out0, pm_out1, dec0, dec1, word_done;

  acs_bitserial_butterfly #(.PM_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pm_in0(pm_in0), .pm_in1(pm_in1),
    .bm_a(bm_a), .bm_b(bm_b), .pm_out0(pm_out0), .pm_out1(pm_out1),
    .dec0(dec0), .dec1(dec1), .word_done(word_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference state
  int    nm0[$];
  int    nm1[$];
  string tag0[$];
  string tag1[$];
  int    w = 0;
  bit    pend_done = 0;
  int    pd0 = 0, pd1 = 0;
  int    exp_dec0 = 0, exp_dec1 = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bit(int j, int word, int idx);
    if (word < 2) return 0;
    if (j == 0) return (nm0[word-2] >> idx) & 1;
    return (nm1[word-2] >> idx) & 1;
  endfunction

  function automatic string exp_tag(int j, int word);
    if (word < 2) return "R7 early";
    if (j == 0) return tag0[word-2];
    return tag1[word-2];
  endfunction

  // one clock: check what the last edge produced, then drive the next inputs
  task automatic step(bit e, bit b0, bit b1, bit ba, bit bb, bit is_last, int idx);
    @(negedge clk);
    if (pend_done) begin
      chk("R6 word_done pulse", int'(word_done), 1);
      chk("R4 dec0", int'(dec0), pd0);
      chk("R4 dec1", int'(dec1), pd1);
      exp_dec0 = pd0;
      exp_dec1 = pd1;
    end else begin
      chk("R6 word_done idle", int'(word_done), 0);
      chk("R4 dec0 hold", int'(dec0), exp_dec0);
      chk("R4 dec1 hold", int'(dec1), exp_dec1);
    end
    // serial outputs are in step with the bit index of the current word
    chk(e ? exp_tag(0, w) : "R2 hold pm_out0", int'(pm_out0), exp_bit(0, w, idx));
    chk(e ? exp_tag(1, w) : "R2 hold pm_out1", int'(pm_out1), exp_bit(1, w, idx));
    pend_done = e && is_last;
    en     = e;
    pm_in0 = b0;
    pm_in1 = b1;
    bm_a   = ba;
    bm_b   = bb;
  endtask

  task automatic run_word(int p0, int p1, int a, int b, int gap, string note);
    int r00, r10, r01, r11, m0, m1, d0, d1;
    r00 = p0 + a;  r10 = p1 + b;
    r01 = p0 + b;  r11 = p1 + a;
    d0 = (r10 < r00) ? 1 : 0;
    d1 = (r11 < r01) ? 1 : 0;
    m0 = d0 ? r10 : r00;
    m1 = d1 ? r11 : r01;
    tag0.push_back((m0 > MAXV) ? {"R5 sat pm_out0 ", note} : {"R3 R7 pm_out0 ", note});
    tag1.push_back((m1 > MAXV) ? {"R5 sat pm_out1 ", note} : {"R3 R7 pm_out1 ", note});
    if (m0 > MAXV) m0 = MAXV;
    if (m1 > MAXV) m1 = MAXV;
    nm0.push_back(m0);
    nm1.push_back(m1);
    for (int i = 0; i < W; i++) begin
      if (i == W - 1) begin
        pd0 = d0;
        pd1 = d1;
      end
      step(1'b1, bit'((p0 >> i) & 1), bit'((p1 >> i) & 1),
           bit'((a >> i) & 1), bit'((b >> i) & 1), (i == W - 1), i);
    end
    w++;
    for (int g = 0; g < gap; g++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0;
    pm_in0 = 1'b0; pm_in1 = 1'b0; bm_a = 1'b0; bm_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pm_out0", int'(pm_out0), 0);
    chk("R1 reset pm_out1", int'(pm_out1), 0);
    chk("R1 reset dec0", int'(dec0), 0);
    chk("R1 reset dec1", int'(dec1), 0);
    chk("R1 reset word_done", int'(word_done), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 idle after release pm_out0", int'(pm_out0), 0);
    chk("R1 idle after release word_done", int'(word_done), 0);

    run_word(0, 0, 0, 0, 0, "zeros");
    run_word(10, 20, 5, 3, 0, "plain");
    run_word(100, 90, 40, 50, 2, "tie");
    run_word(255, 255, 255, 255, 0, "both overflow");
    run_word(200, 10, 100, 5, 1, "one overflow");
    run_word(200, 200, 100, 100, 0, "carry source");
    run_word(0, 0, 0, 0, 0, "R8 after carry");
    run_word(4, 5, 0, 0, 0, "LSB differs");
    run_word(5, 4, 0, 0, 3, "LSB differs swapped");
    run_word(0, 128, 128, 0, 0, "MSB vs sum");
    run_word(127, 1, 1, 127, 0, "tie mid");
    run_word(250, 3, 5, 252, 0, "exact max");
    for (int k = 0; k < 60; k++) begin
      run_word(int'($urandom_range(0, MAXV)), int'($urandom_range(0, MAXV)),
               int'($urandom_range(0, MAXV)), int'($urandom_range(0, 40)),
               (k % 7 == 3) ? 2 : 0, "random");
    end
    run_word(0, 0, 0, 0, 0, "flush");
    run_word(0, 0, 0, 0, 0, "flush");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule